// File: doc/BRIEF.md
# Flow-Controlled UART Transmitter

This block is the transmit half of a serial port with hardware flow control. The host pushes characters into a small transmit queue through a one-cycle write strobe. A serialiser drains the queue and sends each character as an 8N1 frame on `txd`. The line idles high, and each frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. Bit timing comes from an external pulse `bitTick`. Each bit lasts `OVS` ticks, and no state moves on a cycle without a tick.

When both `afcEn` and `fifoEn` are set, the active-low clear-to-send input `ctsN` controls when a new character may begin. A frame already on the line always finishes. Whether the next queued character may follow at once is decided by a single sample of `ctsN` taken in the middle of the stop bit. While transmission is held, host writes are still accepted until the queue is full. A write to a full queue is dropped and sets a sticky `overflow` flag. The host can read the current level and a not-full flag at any time. When `fifoEn` is clear, the queue holds a single character.

Top module: `uart_cts_tx`

## Requirements
- R1: After reset, `txd` is 1, `fifoLevel` is 0, `fifoNotFull` is 1 and `overflow` is 0.
- R2: A frame is one 0 start bit, then 8 data bits LSB first, then one 1 stop bit. Each bit holds for `OVS` ticks. With data queued and sending allowed, `txd` goes low on the first tick edge after the write lands. `txd` never changes on a cycle without `bitTick`.
- R3: Characters leave in the order they were written. `fifoLevel` counts the queued characters, rises by at most one per cycle and never exceeds `DEPTH`.
- R4: Automatic flow control is active only when `afcEn` and `fifoEn` are both 1. Otherwise `ctsN` has no effect, and a queued character starts on the next tick.
- R5: While the line is idle with flow control active and `ctsN` = 1, no frame starts and the queue level is unchanged.
- R6: A frame in progress always completes with all ten bits, even if `ctsN` goes to 1 during it.
- R7: `ctsN` is sampled once per frame, at tick `OVS/2` of the stop bit. If it is 1 there, the next character is held. If it is 0 there, the next queued character starts directly after the stop bit, even if `ctsN` rises later in that stop bit.
- R8: A held character starts on the first tick edge at which `ctsN` is seen as 0.
- R9: Writes are accepted while transmission is held. A write when the queue is full is dropped and sets `overflow`, which stays 1 until reset.
- R10: With `fifoEn` = 0 the queue capacity is one character, so `fifoNotFull` is 0 once a character is queued, and a second write overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | Timing pulse; one bit period is OVS pulses |
| wrEn | input | 1 | Write strobe into the transmit queue |
| wrData | input | DATA_W | Character to queue |
| afcEn | input | 1 | Automatic flow-control enable |
| fifoEn | input | 1 | Queue enable (0: single-entry holding) |
| ctsN | input | 1 | Active-low clear-to-send from the far receiver |
| txd | output | 1 | Serial output, idles high |
| fifoLevel | output | $clog2(DEPTH+1) | Number of queued characters |
| fifoNotFull | output | 1 | Queue can take another character |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
The queue level changes at the write edge. A queued character with a tick present drives `txd` low one edge later, and the bench samples both on the falling edge that follows each of these edges. With `OVS` = 4 and a tick on every cycle, the start of a frame is counted as falling edge 0. Bit k is then sampled at falling edge 4k+2, the stop-bit sample latches at rising edge 38, and a chained frame begins at edge 40. The bench counts falling edges from the detected start bit, so a `ctsN` change made at edge 37 or at edge 38 lands on either side of the sample. It confirms the outcome at falling edge 40.

// File: rtl/uart_cts_pkg.sv
package uart_cts_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } txState_t;

  // Strobes issued by the control to the datapath, at most one per cycle.
  typedef struct packed {
    logic loadChar;  // pop queue head into shifter, drive start bit
    logic shiftBit;  // drive next data bit
    logic markHigh;  // drive stop level
  } txStrobes_t;

endpackage

// File: rtl/uart_cts_fifo.sv
module uart_cts_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              fifoEn,
  input  logic              popEn,
  output logic [DATA_W-1:0] rdData,
  output logic [LVL_W-1:0]  level,
  output logic              notFull,
  output logic              empty,
  output logic              overflow
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [LVL_W-1:0]  capacity;
  logic              accept;

  function automatic logic [PTR_W-1:0] ptrNext(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Disabled queue behaves as a single holding slot.
  assign capacity = fifoEn ? LVL_W'(DEPTH) : LVL_W'(1);
  assign notFull  = (level < capacity);
  assign empty    = (level == '0);
  assign accept   = wrEn && notFull;
  assign rdData   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (accept) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (accept) wrPtr <= ptrNext(wrPtr);
      if (popEn)  rdPtr <= ptrNext(rdPtr);
      case ({accept, popEn})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (wrEn && !notFull) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_cts_datapath.sv
module uart_cts_datapath
  import uart_cts_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              fifoEn,
  input  txStrobes_t        strb,
  output logic              txd,
  output logic              fifoEmpty,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic              fifoNotFull,
  output logic              overflow
);

  logic [DATA_W-1:0] headData;
  logic [DATA_W-1:0] shReg;

  uart_cts_fifo #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W),
    .LVL_W (LVL_W)
  ) u_fifo (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .fifoEn  (fifoEn),
    .popEn   (strb.loadChar),
    .rdData  (headData),
    .level   (fifoLevel),
    .notFull (fifoNotFull),
    .empty   (fifoEmpty),
    .overflow(overflow)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txd   <= 1'b1;
      shReg <= '0;
    end else if (strb.loadChar) begin
      shReg <= headData;
      txd   <= 1'b0;
    end else if (strb.shiftBit) begin
      txd   <= shReg[0];
      shReg <= {1'b0, shReg[DATA_W-1:1]};
    end else if (strb.markHigh) begin
      txd   <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_cts_ctrl.sv
module uart_cts_ctrl
  import uart_cts_pkg::*;
#(
  parameter int OVS    = 4,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       fifoEmpty,
  input  logic       afcEn,
  input  logic       fifoEn,
  input  logic       ctsN,
  output txStrobes_t strb,
  output logic       frameBusy
);

  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  txState_t         state, stateNx;
  logic [SUB_W-1:0] subCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             ctsHold;
  logic             autoActive, mayStartNow, mayChain, bitEnd;

  assign autoActive  = afcEn && fifoEn;
  assign mayStartNow = !fifoEmpty && !(autoActive && ctsN);
  assign mayChain    = !fifoEmpty && !ctsHold;
  assign bitEnd      = bitTick && (subCnt == SUB_LAST);
  assign frameBusy   = (state != ST_IDLE);

  always_comb begin
    strb    = '0;
    stateNx = state;
    unique case (state)
      ST_IDLE: begin
        if (bitTick && mayStartNow) begin
          strb.loadChar = 1'b1;
          stateNx       = ST_START;
        end
      end
      ST_START: begin
        if (bitEnd) begin
          strb.shiftBit = 1'b1;
          stateNx       = ST_DATA;
        end
      end
      ST_DATA: begin
        if (bitEnd) begin
          if (bitIdx == BIT_LAST) begin
            strb.markHigh = 1'b1;
            stateNx       = ST_STOP;
          end else begin
            strb.shiftBit = 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (bitEnd) begin
          if (mayChain) begin
            strb.loadChar = 1'b1;
            stateNx       = ST_START;
          end else begin
            stateNx = ST_IDLE;
          end
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      subCnt  <= '0;
      bitIdx  <= '0;
      ctsHold <= 1'b0;
    end else begin
      state <= stateNx;
      if (state == ST_IDLE || strb.loadChar) subCnt <= '0;
      else if (bitTick) subCnt <= bitEnd ? '0 : subCnt + 1'b1;
      if (state == ST_START && bitEnd)     bitIdx <= '0;
      else if (state == ST_DATA && bitEnd) bitIdx <= bitIdx + 1'b1;
      // Single flow-control sample per frame, mid stop bit.
      if (state == ST_STOP && bitTick && subCnt == SUB_MID)
        ctsHold <= autoActive && ctsN;
    end
  end

endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
  import uart_cts_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int OVS    = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              afcEn,
  input  logic              fifoEn,
  input  logic              ctsN,
  output logic              txd,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic              fifoNotFull,
  output logic              overflow
);

  txStrobes_t strb;
  logic       fifoEmpty;
  logic       frameBusy;

  uart_cts_ctrl #(
    .OVS   (OVS),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitTick  (bitTick),
    .fifoEmpty(fifoEmpty),
    .afcEn    (afcEn),
    .fifoEn   (fifoEn),
    .ctsN     (ctsN),
    .strb     (strb),
    .frameBusy(frameBusy)
  );

  uart_cts_datapath #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W),
    .LVL_W (LVL_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .fifoEn     (fifoEn),
    .strb       (strb),
    .txd        (txd),
    .fifoEmpty  (fifoEmpty),
    .fifoLevel  (fifoLevel),
    .fifoNotFull(fifoNotFull),
    .overflow   (overflow)
  );

endmodule

// File: rtl/uart_cts_checker.sv
module uart_cts_checker #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             bitTick,
  input logic             afcEn,
  input logic             fifoEn,
  input logic             ctsN,
  input logic             txd,
  input logic [LVL_W-1:0] fifoLevel,
  input logic             overflow,
  input logic             frameBusy
);

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVL_W'(DEPTH));

  assert_level_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ({1'b0, fifoLevel} <= {1'b0, $past(fifoLevel)} + 1'b1));

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!frameBusy && afcEn && fifoEn && ctsN) |=> !frameBusy);

  assert_tick_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> ($stable(txd) && $stable(frameBusy)));

  assert_idle_line_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    !frameBusy |-> txd);

  assert_ignore_cts_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!(afcEn && fifoEn) && !frameBusy && bitTick && fifoLevel != '0) |=> frameBusy);

endmodule

bind uart_cts_tx uart_cts_checker #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .bitTick  (bitTick),
  .afcEn    (afcEn),
  .fifoEn   (fifoEn),
  .ctsN     (ctsN),
  .txd      (txd),
  .fifoLevel(fifoLevel),
  .overflow (overflow),
  .frameBusy(frameBusy)
);

// File: tb/uart_cts_tx_bench.sv
module uart_cts_tx_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b1;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       afcEn = 1'b0;
  logic       fifoEn = 1'b1;
  logic       ctsN = 1'b0;
  logic       txd;
  logic [4:0] fifoLevel;
  logic       fifoNotFull;
  logic       overflow;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_cts_tx u_uart_cts_tx (
    .clk        (clk),
    .rstN       (rstN),
    .bitTick    (bitTick),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .afcEn      (afcEn),
    .fifoEn     (fifoEn),
    .ctsN       (ctsN),
    .txd        (txd),
    .fifoLevel  (fifoLevel),
    .fifoNotFull(fifoNotFull),
    .overflow   (overflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    wrEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk);
    wrEn   = 1'b1;
    wrData = b;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  // Leaves the bench at falling edge 0 of a frame (txd low).
  task automatic waitStart();
    int cnt = 0;
    while (txd !== 1'b0 && cnt < 3000) begin
      @(negedge clk);
      cnt++;
    end
    if (txd !== 1'b0) chk("R2 start bit seen", 32'(txd), 32'h0);
  endtask

  task automatic decode(input bit atStart, output logic [7:0] b, output bit framed);
    framed = 1'b1;
    if (!atStart) waitStart();
    repeat (2) @(negedge clk);
    if (txd !== 1'b0) framed = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (4) @(negedge clk);
      b[i] = txd;
    end
    repeat (4) @(negedge clk);
    if (txd !== 1'b1) framed = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 txd idle", 32'(txd), 32'h1);
    chk("R1 level", 32'(fifoLevel), 32'h0);
    chk("R1 notFull", 32'(fifoNotFull), 32'h1);
    chk("R1 overflow", 32'(overflow), 32'h0);
  endtask

  task automatic testBasicFrame();
    logic [7:0] b;
    bit f;
    afcEn = 1'b0; fifoEn = 1'b1; ctsN = 1'b0;
    pushByte(8'hA5);
    chk("R3 level after write", 32'(fifoLevel), 32'h1);
    chk("R2 txd before start", 32'(txd), 32'h1);
    @(negedge clk);
    chk("R2 start one edge later", 32'(txd), 32'h0);
    chk("R3 level after pop", 32'(fifoLevel), 32'h0);
    decode(1'b1, b, f);
    chk("R2 frame data", 32'(b), 32'hA5);
    chk("R2 framing bits", 32'(f), 32'h1);
  endtask

  task automatic testOrder();
    logic [7:0] b;
    bit f;
    bitTick = 1'b0;
    pushByte(8'h01);
    pushByte(8'h80);
    pushByte(8'h6E);
    repeat (3) @(negedge clk);
    chk("R2 no start without tick", 32'(txd), 32'h1);
    chk("R3 level of three", 32'(fifoLevel), 32'h3);
    bitTick = 1'b1;
    decode(1'b0, b, f);
    chk("R3 order first", 32'(b), 32'h01);
    decode(1'b0, b, f);
    chk("R3 order second", 32'(b), 32'h80);
    decode(1'b0, b, f);
    chk("R3 order third", 32'(b), 32'h6E);
    chk("R2 framing of third", 32'(f), 32'h1);
  endtask

  task automatic testFillOverflow();
    logic [7:0] b;
    bit f;
    bitTick = 1'b0;
    for (int i = 0; i < 5; i++) pushByte(8'(8'h10 + i));
    chk("R3 level five", 32'(fifoLevel), 32'h5);
    chk("R3 notFull at five", 32'(fifoNotFull), 32'h1);
    for (int i = 5; i < 16; i++) pushByte(8'(8'h10 + i));
    chk("R3 level full", 32'(fifoLevel), 32'd16);
    chk("R3 notFull at full", 32'(fifoNotFull), 32'h0);
    chk("R9 no overflow yet", 32'(overflow), 32'h0);
    pushByte(8'hEE);
    chk("R9 overflow set", 32'(overflow), 32'h1);
    chk("R9 level unchanged by dropped write", 32'(fifoLevel), 32'd16);
    bitTick = 1'b1;
    decode(1'b0, b, f);
    chk("R3 head after fill", 32'(b), 32'h10);
    decode(1'b0, b, f);
    chk("R3 second after fill", 32'(b), 32'h11);
    chk("R9 overflow sticky", 32'(overflow), 32'h1);
    doReset();
    chk("R1 overflow cleared by reset", 32'(overflow), 32'h0);
  endtask

  task automatic testHoldResume();
    logic [7:0] b;
    bit f;
    int lows = 0;
    afcEn = 1'b1; fifoEn = 1'b1; ctsN = 1'b1;
    pushByte(8'h3C);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    chk("R5 no start while held", 32'(lows), 32'h0);
    chk("R5 level kept", 32'(fifoLevel), 32'h1);
    pushByte(8'hC3);
    chk("R9 write accepted while held", 32'(fifoLevel), 32'h2);
    @(negedge clk);
    ctsN = 1'b0;
    @(negedge clk);
    chk("R8 start at first tick after release", 32'(txd), 32'h0);
    decode(1'b1, b, f);
    chk("R8 held char", 32'(b), 32'h3C);
    decode(1'b0, b, f);
    chk("R8 next char", 32'(b), 32'hC3);
  endtask

  task automatic testMidFrame();
    logic [7:0] b;
    bit f;
    afcEn = 1'b1; fifoEn = 1'b1; ctsN = 1'b0;
    pushByte(8'h96);
    fork
      begin
        repeat (10) @(negedge clk);
        ctsN = 1'b1;
      end
    join_none
    decode(1'b0, b, f);
    chk("R6 frame completes data", 32'(b), 32'h96);
    chk("R6 frame completes framing", 32'(f), 32'h1);
    repeat (2) @(negedge clk);
    ctsN = 1'b0;
  endtask

  task automatic testStopSample(input bit late);
    logic [7:0] b;
    bit f;
    afcEn = 1'b1; fifoEn = 1'b1; ctsN = 1'b0;
    @(negedge clk);
    wrEn = 1'b1; wrData = 8'h5C;
    @(negedge clk);
    wrData = 8'hD2;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R7 first frame started", 32'(txd), 32'h0);
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == (late ? 38 : 37)) ctsN = 1'b1;
      if (k == 38) chk("R7 stop bit level", 32'(txd), 32'h1);
    end
    if (late) begin
      chk("R7 late rise still chains", 32'(txd), 32'h0);
      chk("R7 late rise level", 32'(fifoLevel), 32'h0);
      ctsN = 1'b0;
      decode(1'b1, b, f);
      chk("R7 chained char", 32'(b), 32'hD2);
    end else begin
      chk("R7 early rise holds", 32'(txd), 32'h1);
      chk("R7 early rise level", 32'(fifoLevel), 32'h1);
      repeat (20) @(negedge clk);
      chk("R7 still held", 32'(txd), 32'h1);
      ctsN = 1'b0;
      decode(1'b0, b, f);
      chk("R7 held char after release", 32'(b), 32'hD2);
    end
  endtask

  task automatic testCtsIgnored();
    logic [7:0] b;
    bit f;
    afcEn = 1'b0; fifoEn = 1'b1; ctsN = 1'b1;
    pushByte(8'h5A);
    @(negedge clk);
    chk("R4 afc off starts", 32'(txd), 32'h0);
    decode(1'b1, b, f);
    chk("R4 afc off data", 32'(b), 32'h5A);
    afcEn = 1'b1; fifoEn = 1'b0;
    pushByte(8'hA3);
    @(negedge clk);
    chk("R4 fifo off starts", 32'(txd), 32'h0);
    decode(1'b1, b, f);
    chk("R4 fifo off data", 32'(b), 32'hA3);
    ctsN = 1'b0; afcEn = 1'b0; fifoEn = 1'b1;
  endtask

  task automatic testSingleSlot();
    doReset();
    bitTick = 1'b0; fifoEn = 1'b0;
    pushByte(8'h11);
    chk("R10 level one", 32'(fifoLevel), 32'h1);
    chk("R10 full at one", 32'(fifoNotFull), 32'h0);
    chk("R10 no overflow yet", 32'(overflow), 32'h0);
    pushByte(8'h22);
    chk("R10 second write overflows", 32'(overflow), 32'h1);
    chk("R10 level stays one", 32'(fifoLevel), 32'h1);
  endtask

  initial begin
    doReset();
    testReset();
    testBasicFrame();
    testOrder();
    testFillOverflow();
    testHoldResume();
    testMidFrame();
    testStopSample(1'b0);
    testStopSample(1'b1);
    testCtsIgnored();
    testSingleSlot();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog (all) actual=timeout expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule